// File: doc/BRIEF.md
# Block Variance Edge Classifier

This block inspects one rectangular image block, streamed in raster order, and decides how much of it is edge content. For every pixel whose 3×3 neighbourhood lies fully inside the block, it forms the neighbourhood from two internal line delays. It then computes the rounded neighbourhood mean and a variance. Each such pixel gets a label of uniform, texture or edge from two programmable variance thresholds.

When the final pixel of the block has passed through the pipeline, the label counts place the block in one of six categories. The category selects a strong-edge fraction from a parameter table, and a later hysteresis stage uses that fraction to set its thresholds. The fraction and the category are presented together with a one-cycle valid pulse. They stay on the outputs until the next result is produced.

A start pulse opens each block. It clears the position counters, the label counters and any result still in the pipeline.

Top module: `edge_var_classifier`

## Requirements
- R1: After reset, `p1Valid` is 0 and both `p1Value` and `blkClass` are 0.
- R2: For a neighbourhood with pixel sum S, the mean is S/9 rounded to the nearest integer. The variance is the sum of the nine squared differences from that mean, shifted right by 3 bits.
- R3: A counted pixel is labelled edge when its variance is greater than or equal to `thrEdge`. Otherwise it is labelled uniform when its variance is less than `thrUniform`. Otherwise it is labelled texture.
- R4: Only pixels whose full 3×3 window lies inside the block are counted. N = (BLK_W-2)·(BLK_H-2) pixels are counted per block.
- R5: The block category is chosen in this priority order, with nE, nU and nT the label counts:
  - code 5, strong edge: 10·nE ≥ 3·N.
  - code 4, medium edge: 10·nE ≥ N.
  - code 3, edge/texture: nE > 0.
  - code 0, uniform: 10·nU ≥ 3·N and nT = 0.
  - code 1, uniform/texture: 10·nU ≥ 3·N and nT > 0.
  - code 2, texture: all other cases.
- R6: `p1Value` equals the P1_W-bit entry of `P1_TABLE` at bit offset code·P1_W, where code is the category reported on `blkClass`.
- R7: `p1Valid` is high for exactly one cycle, four rising edges after the edge that accepts the last pixel of the block. `p1Value` and `blkClass` change only in that cycle and hold their values between results.
- R8: A pixel offered in the same cycle as `startBlk` is not accepted. Pixels offered after the last pixel of a block are ignored until the next `startBlk`, and they produce no result.
- R9: `startBlk` restarts the raster position and clears the label counts. It also discards a result that is still in the pipeline, so no `p1Valid` follows the pulse.
- R10: Cycles with `pixValid` low may appear anywhere in the stream and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startBlk | input | 1 | Opens a new block and clears all progress |
| pixValid | input | 1 | Pixel strobe |
| pixData | input | PIX_W | Pixel intensity, raster order |
| thrUniform | input | 2·PIX_W+1 | Variance below this marks a uniform pixel |
| thrEdge | input | 2·PIX_W+1 | Variance at or above this marks an edge pixel |
| p1Value | output | P1_W | Selected strong-edge fraction, unsigned fixed point |
| blkClass | output | 3 | Block category code (R5) |
| p1Valid | output | 1 | One-cycle result strobe |

## Verification
The assertions watch on every cycle the properties that concern timing:
- the result strobe lasts a single cycle and sits exactly four edges after the last accepted pixel;
- the outputs hold between results;
- no pixel is accepted alongside a start pulse or after a block has finished;
- a start pulse suppresses any pending result.

The arithmetic cannot be checked that way. This covers the rounded mean, the shifted variance, the threshold ordering, the border exclusion and the category priority. The bench shows these by sweeping both thresholds across the exact variance values of each test image, so that any error of one in a variance moves a pixel into another label.

// File: rtl/edge_var_pkg.sv
package edge_var_pkg;

  typedef enum logic [1:0] {
    LBL_UNI  = 2'd0,
    LBL_TEX  = 2'd1,
    LBL_EDGE = 2'd2
  } pixLabel_t;

  typedef enum logic [2:0] {
    CLS_UNIFORM  = 3'd0,
    CLS_UNI_TEX  = 3'd1,
    CLS_TEXTURE  = 3'd2,
    CLS_EDGE_TEX = 3'd3,
    CLS_MED_EDGE = 3'd4,
    CLS_STRONG   = 3'd5
  } blkClass_t;

  localparam int NUM_CLASSES = 6;

  // Strobes from the raster control to the datapath
  typedef struct packed {
    logic clear;     // start of block: flush everything
    logic accept;    // pixel taken this cycle
    logic interior;  // accepted pixel completes an in-block 3x3 window
    logic last;      // accepted pixel is the final one of the block
  } ctlStrobe_t;

endpackage

// File: rtl/edge_var_ctl.sv
module edge_var_ctl
  import edge_var_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int BLK_H = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBlk,
  input  logic       pixValid,
  output ctlStrobe_t strobe
);

  localparam int COL_W = $clog2(BLK_W);
  localparam int ROW_W = $clog2(BLK_H);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(BLK_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(BLK_H - 1);

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             blkDone;
  logic             atLastCol;

  always_comb begin
    atLastCol       = (col == LAST_COL);
    strobe.clear    = startBlk;
    strobe.accept   = pixValid && !startBlk && !blkDone;
    strobe.interior = strobe.accept && (row >= ROW_W'(2)) && (col >= COL_W'(2));
    strobe.last     = strobe.accept && atLastCol && (row == LAST_ROW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      col     <= '0;
      row     <= '0;
      blkDone <= 1'b0;
    end else if (startBlk) begin
      col     <= '0;
      row     <= '0;
      blkDone <= 1'b0;
    end else if (strobe.accept) begin
      if (atLastCol) begin
        col <= '0;
        if (row == LAST_ROW) begin
          row     <= '0;
          blkDone <= 1'b1;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end

endmodule

// File: rtl/edge_var_dp.sv
module edge_var_dp
  import edge_var_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int BLK_H = 16,
  parameter int PIX_W = 8,
  parameter int P1_W  = 8,
  parameter logic [NUM_CLASSES*P1_W-1:0] P1_TABLE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [PIX_W-1:0]  pixData,
  input  logic [2*PIX_W:0]  thrUniform,
  input  logic [2*PIX_W:0]  thrEdge,
  output logic [P1_W-1:0]   p1Value,
  output logic [2:0]        blkClass,
  output logic              p1Valid
);

  localparam int VAR_W  = 2*PIX_W + 1;
  localparam int SUM_W  = PIX_W + 4;
  localparam int FRAC   = SUM_W + 4;
  localparam int PROD_W = SUM_W + FRAC;
  localparam logic [PROD_W-1:0] RECIP9 = PROD_W'(((2**FRAC) + 4) / 9);
  localparam logic [PROD_W-1:0] HALF   = PROD_W'(2**(FRAC-1));
  localparam int SQ_W   = 2*PIX_W + 4;
  localparam int NPIX   = (BLK_W - 2) * (BLK_H - 2);
  localparam int CNT_W  = $clog2(NPIX + 1);
  localparam int CMP_W  = CNT_W + 4;
  localparam logic [CMP_W-1:0] LIM30 = CMP_W'(3 * NPIX);
  localparam logic [CMP_W-1:0] LIM10 = CMP_W'(NPIX);

  // Two-row delay line and 3x3 window (row 0 = oldest line)
  logic [PIX_W-1:0] lineDly [2*BLK_W];
  logic [PIX_W-1:0] newCol  [3];
  logic [PIX_W-1:0] win     [3][3];

  always_comb begin
    newCol[0] = lineDly[2*BLK_W-1];
    newCol[1] = lineDly[BLK_W-1];
    newCol[2] = pixData;
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      lineDly[0] <= pixData;
      for (int i = 1; i < 2*BLK_W; i++) lineDly[i] <= lineDly[i-1];
      for (int r = 0; r < 3; r++) begin
        win[r][0] <= win[r][1];
        win[r][1] <= win[r][2];
        win[r][2] <= newCol[r];
      end
    end
  end

  // Mean and variance of the window
  logic [SUM_W-1:0]  winSum;
  logic [PROD_W-1:0] meanProd;
  logic [PIX_W-1:0]  winMean;
  logic [SQ_W-1:0]   sqSum;
  logic [PIX_W-1:0]  absDev;
  logic [VAR_W-1:0]  varComb;

  always_comb begin
    winSum = '0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        winSum = winSum + SUM_W'(win[r][c]);
    meanProd = PROD_W'(winSum) * RECIP9 + HALF;
    winMean  = PIX_W'(meanProd >> FRAC);
    sqSum    = '0;
    absDev   = '0;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++) begin
        absDev = (win[r][c] >= winMean) ? (win[r][c] - winMean) : (winMean - win[r][c]);
        sqSum  = sqSum + SQ_W'(absDev) * SQ_W'(absDev);
      end
    varComb = VAR_W'(sqSum >> 3);
  end

  // Pipeline registers and label counters
  logic             winValid, winLast, varValid, varLast, doneStage;
  logic [VAR_W-1:0] varReg;
  logic [CNT_W-1:0] cntUni, cntTex, cntEdge;
  pixLabel_t        pixLabel;
  blkClass_t        clsNext, clsReg;

  always_comb begin
    if (varReg >= thrEdge)        pixLabel = LBL_EDGE;
    else if (varReg < thrUniform) pixLabel = LBL_UNI;
    else                          pixLabel = LBL_TEX;
  end

  always_ff @(posedge clk) begin
    if (winValid) varReg <= varComb;
  end

  // Category decision: edge level first, then uniform/texture split
  logic [CMP_W-1:0] edgeTen, uniTen;
  always_comb begin
    edgeTen = CMP_W'(cntEdge) * CMP_W'(10);
    uniTen  = CMP_W'(cntUni) * CMP_W'(10);
    if (edgeTen >= LIM30)      clsNext = CLS_STRONG;
    else if (edgeTen >= LIM10) clsNext = CLS_MED_EDGE;
    else if (cntEdge != '0)    clsNext = CLS_EDGE_TEX;
    else if (uniTen >= LIM30)  clsNext = (cntTex == '0) ? CLS_UNIFORM : CLS_UNI_TEX;
    else                       clsNext = CLS_TEXTURE;
  end

  logic [P1_W-1:0] p1Lut [NUM_CLASSES];
  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_lut
    assign p1Lut[g] = P1_TABLE[g*P1_W +: P1_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {winValid, winLast, varValid, varLast, doneStage, p1Valid} <= '0;
      {cntUni, cntTex, cntEdge} <= '0;
      p1Value <= '0;
      clsReg  <= CLS_UNIFORM;
    end else if (strobe.clear) begin
      {winValid, winLast, varValid, varLast, doneStage, p1Valid} <= '0;
      {cntUni, cntTex, cntEdge} <= '0;
    end else begin
      winValid  <= strobe.interior;
      winLast   <= strobe.last;
      varValid  <= winValid;
      varLast   <= winLast;
      doneStage <= varLast;
      p1Valid   <= doneStage;
      if (varValid) begin
        unique case (pixLabel)
          LBL_UNI:  cntUni  <= cntUni + 1'b1;
          LBL_TEX:  cntTex  <= cntTex + 1'b1;
          default:  cntEdge <= cntEdge + 1'b1;
        endcase
      end
      if (doneStage) begin
        clsReg  <= clsNext;
        p1Value <= p1Lut[clsNext];
      end
    end
  end

  assign blkClass = clsReg;

endmodule

// File: rtl/edge_var_classifier.sv
module edge_var_classifier
  import edge_var_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int BLK_H = 16,
  parameter int PIX_W = 8,
  parameter int P1_W  = 8,
  parameter logic [6*P1_W-1:0] P1_TABLE = {8'd51, 8'd26, 8'd13, 8'd0, 8'd0, 8'd0}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBlk,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  input  logic [2*PIX_W:0] thrUniform,
  input  logic [2*PIX_W:0] thrEdge,
  output logic [P1_W-1:0]  p1Value,
  output logic [2:0]       blkClass,
  output logic             p1Valid
);

  ctlStrobe_t strobe;

  edge_var_ctl #(.BLK_W(BLK_W), .BLK_H(BLK_H)) u_ctl (
    .clk(clk), .rstN(rstN), .startBlk(startBlk), .pixValid(pixValid), .strobe(strobe)
  );

  edge_var_dp #(
    .BLK_W(BLK_W), .BLK_H(BLK_H), .PIX_W(PIX_W), .P1_W(P1_W), .P1_TABLE(P1_TABLE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixData(pixData),
    .thrUniform(thrUniform), .thrEdge(thrEdge),
    .p1Value(p1Value), .blkClass(blkClass), .p1Valid(p1Valid)
  );

endmodule

// File: rtl/edge_var_classifier_chk.sv
module edge_var_classifier_chk
  import edge_var_pkg::*;
#(
  parameter int P1_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            startBlk,
  input ctlStrobe_t      strobe,
  input logic            p1Valid,
  input logic [P1_W-1:0] p1Value,
  input logic [2:0]      blkClass
);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    p1Valid |=> !p1Valid);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    p1Valid |-> $past(strobe.last, 4));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !p1Valid |-> ($stable(p1Value) && $stable(blkClass)));

  a_r5_class_range: assert property (@(posedge clk) disable iff (!rstN)
    p1Valid |-> (blkClass <= 3'd5));

  a_r8_no_accept_on_start: assert property (@(posedge clk) disable iff (!rstN)
    startBlk |-> !strobe.accept);

  a_r8_closed_after_last: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> !strobe.accept);

  a_r4_last_is_interior: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |-> strobe.interior);

  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    startBlk |=> !p1Valid);

endmodule

bind edge_var_classifier edge_var_classifier_chk #(.P1_W(P1_W)) u_chk (
  .clk(clk), .rstN(rstN), .startBlk(startBlk), .strobe(strobe),
  .p1Valid(p1Valid), .p1Value(p1Value), .blkClass(blkClass)
);

// File: tb/edge_var_classifier_bench.sv
module edge_var_classifier_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int H = 5;
  localparam int N = (W-2)*(H-2);
  localparam logic [47:0] TB_TABLE = {8'd51, 8'd26, 8'd13, 8'd9, 8'd5, 8'd0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startBlk = 1'b0;
  logic        pixValid = 1'b0;
  logic [7:0]  pixData = '0;
  logic [16:0] thrUniform = '0;
  logic [16:0] thrEdge = '0;
  logic [7:0]  p1Value;
  logic [2:0]  blkClass;
  logic        p1Valid;

  int checks = 0;
  int fails = 0;
  int unsigned seed = 32'h1234abcd;
  int img [H][W];
  int vList [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_var_classifier #(.BLK_W(W), .BLK_H(H), .PIX_W(8), .P1_W(8), .P1_TABLE(TB_TABLE)) u_edge_var_classifier (
    .clk(clk), .rstN(rstN), .startBlk(startBlk), .pixValid(pixValid), .pixData(pixData),
    .thrUniform(thrUniform), .thrEdge(thrEdge),
    .p1Value(p1Value), .blkClass(blkClass), .p1Valid(p1Valid)
  );

  function automatic int rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 16);
  endfunction

  // R2: rounded mean, squared deviations, shift by 3
  function automatic int varAt(int r, int c);
    int s = 0, m, q = 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) s += img[r+dr][c+dc];
    m = (s + 4) / 9;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++) q += (img[r+dr][c+dc]-m)*(img[r+dr][c+dc]-m);
    return q >> 3;
  endfunction

  // R3, R4, R5 reference
  function automatic int modelClass(int tu, int te);
    int nU = 0, nT = 0, nE = 0, v;
    for (int r = 1; r < H-1; r++)
      for (int c = 1; c < W-1; c++) begin
        v = varAt(r, c);
        if (v >= te) nE++;
        else if (v < tu) nU++;
        else nT++;
      end
    if (nE*10 >= 3*N) return 5;
    if (nE*10 >= N) return 4;
    if (nE > 0) return 3;
    if (nU*10 >= 3*N) return (nT == 0) ? 0 : 1;
    return 2;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic makeImage(int p);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        case (p % 10)
          0: img[r][c] = 100;
          1: img[r][c] = rnd() % 256;
          2: img[r][c] = 120 + rnd() % 8;
          3: img[r][c] = (c < 3) ? 20 : 220;
          4: img[r][c] = ((r + c) % 2) ? 255 : 0;
          5: img[r][c] = r*40 + c*7;
          6: img[r][c] = rnd() % 24;
          7: img[r][c] = ((r < 2) ? 30 : 200) + rnd() % 5;
          8: img[r][c] = 200 + rnd() % 56;
          default: img[r][c] = (rnd() % 7 == 0) ? 250 : 10;
        endcase
      end
    for (int i = 0; i < N; i++) vList[i] = varAt(1 + i / (W-2), 1 + i % (W-2));
  endtask

  // Streams the image; the final pixel is driven at the last negedge. Returns 1 if p1Valid seen.
  task automatic streamImg(bit gaps, output bit sawValid);
    sawValid = 0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps) begin
          while (rnd() % 4 == 0) begin
            @(negedge clk);
            if (p1Valid) sawValid = 1;
            startBlk = 1'b0;
            pixValid = 1'b0;
            pixData  = 8'hff;
          end
        end
        @(negedge clk);
        if (p1Valid) sawValid = 1;
        startBlk = 1'b0;
        pixValid = 1'b1;
        pixData  = 8'(img[r][c]);
      end
  endtask

  task automatic runBlock(int tu, int te, bit gaps, bit garbageOnStart);
    bit early, timingOk;
    int expCls, gotCls, gotP1;
    thrUniform = 17'(tu);
    thrEdge    = 17'(te);
    @(negedge clk);
    startBlk = 1'b1;
    pixValid = garbageOnStart;
    pixData  = 8'h5a;
    streamImg(gaps, early);
    expCls = modelClass(tu, te);
    timingOk = !early;
    gotCls = 0;
    gotP1 = 0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) pixValid = 1'b0;
      if (p1Valid != (k == 4)) timingOk = 0;
      if (k == 4) begin
        gotCls = int'(blkClass);
        gotP1  = int'(p1Value);
      end
      if (k == 5) check((int'(blkClass) == gotCls) && (int'(p1Value) == gotP1),
                        "R7 outputs held after pulse", int'(p1Value), gotP1);
    end
    check(timingOk, "R7/R10 single pulse four edges after last pixel", int'(timingOk), 1);
    check(gotCls == expCls, "R2/R3/R4/R5 block category", gotCls, expCls);
    check(gotP1 == int'(TB_TABLE[expCls*8 +: 8]), "R6 P1 table entry", gotP1, int'(TB_TABLE[expCls*8 +: 8]));
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(p1Valid == 1'b0, "R1 p1Valid after reset", int'(p1Valid), 0);
    check(p1Value == 8'd0, "R1 p1Value after reset", int'(p1Value), 0);
    check(blkClass == 3'd0, "R1 blkClass after reset", int'(blkClass), 0);

    // Threshold sweep across each image's own variances (R2, R3, R4, R5, R6, R10)
    for (int p = 0; p < 10; p++) begin
      makeImage(p);
      for (int i = 0; i < N; i++)
        for (int se = 0; se < 2; se++)
          for (int j = 0; j < N; j += 4)
            for (int su = 0; su < 2; su++)
              runBlock(vList[j] + su, vList[i] + se, ((i + j + p) % 2) == 1, 1'b0);
    end

    // Fixed threshold corner: edge priority over uniform when thresholds cross (R3)
    makeImage(1);
    runBlock(131071, 0, 1'b0, 1'b0);
    runBlock(0, 131071, 1'b0, 1'b0);

    // R8: pixel offered together with startBlk is dropped
    makeImage(5);
    runBlock(vList[3], vList[8], 1'b0, 1'b1);
    makeImage(1);
    runBlock(vList[2], vList[6] + 1, 1'b1, 1'b1);

    // R8: a second image without startBlk produces no result
    makeImage(4);
    streamImg(1'b0, seen);
    seen = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      pixValid = (k < 30);
      pixData  = 8'(rnd());
      if (p1Valid && k > 5) seen = 1;
    end
    check(!seen, "R8 pixels after block end ignored", int'(seen), 0);

    // R9: partial block then restart
    makeImage(9);
    @(negedge clk);
    startBlk = 1'b1;
    pixValid = 1'b0;
    for (int k = 0; k < 17; k++) begin
      @(negedge clk);
      startBlk = 1'b0;
      pixValid = 1'b1;
      pixData  = 8'(rnd());
    end
    runBlock(vList[1], vList[5], 1'b0, 1'b0);

    // R9: start right after the last pixel discards the pending result
    makeImage(3);
    @(negedge clk);
    startBlk = 1'b1;
    streamImg(1'b0, seen);
    @(negedge clk);
    pixValid = 1'b0;
    startBlk = 1'b1;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      startBlk = 1'b0;
      if (p1Valid) seen = 1;
    end
    check(!seen, "R9 pending result dropped by start", int'(seen), 0);

    finishRun();
  end

endmodule